// File: doc/BRIEF.md
# Cascaded Periodic Pulse Generator

This block produces a repeating pulse train on a single clock using two counters placed one after the other. The first stage is a long period counter that counts down without stopping. Each time it reaches zero it raises a one-cycle tick, reloads its stored period, and keeps counting. The tick is the only thing that starts the second stage. That stage is a short width counter, and its output stays high for a programmed number of cycles.

Software or a parent block writes a new period through a load strobe. The new value applies at once and the current interval starts over. The pulse width is a live input that is read only in the cycle when a tick is present. Because every flop samples on the same rising edge, the tick only has to last one cycle. The width stage reads it on the edge that follows it. No pulse stretching and no synchronizer is needed.

The width stage is a two-state machine. `W_IDLE` holds the output low. `W_RUN` holds the output high while a remaining-cycle count runs down. These are its transitions:
- **start**: from `W_IDLE` to `W_RUN` on a tick when the width is non-zero.
- **retrigger**: from `W_RUN` to `W_RUN` on a tick when the width is non-zero. The count is reloaded.
- **expire**: from `W_RUN` to `W_IDLE` when the count is exhausted and no tick is present.
- **cancel**: from `W_RUN` to `W_IDLE` on a tick when the width is zero.
- **hold**: any stage stays where it is when no tick is present, apart from the count-down in `W_RUN`.

Top module: `pgen_pulse_train`

## Requirements
- R1: While `rst` is high at a rising edge, `tick` and `pulse` are 0 after that edge. The stored period and both counts are cleared too, so after reset, with no load, `tick` is high in every cycle.
- R2: A load at edge L stores `load_period`=P and sets the count to P. The next tick is high in the cycle after edge L+P+1.
- R3: With no load, ticks come every P+1 cycles. When P is 1 or more, each tick is one cycle long.
- R4: `load_period` has no effect unless `load_en` is high.
- R5: A tick high in the cycle after edge T, with `pulse_width`=W (W ≥ 1) in that cycle, makes `pulse` high for exactly W cycles, starting after edge T+1.
- R6: A tick when `pulse_width` is 0 produces no pulse. It also ends a pulse that is in progress, from the next edge on.
- R7: A tick that arrives while `pulse` is high restarts the pulse with the full width W, counted from that tick.
- R8: `pulse_width` is sampled only in tick cycles. Changing it at other times does not change the pulse length.
- R9: `load_en` takes priority over reaching terminal count. The cycle after a load never has `tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Strobe that writes a new period |
| load_period | input | 28 | Period value P; ticks are spaced P+1 cycles apart |
| pulse_width | input | 8 | Pulse length in cycles; read in tick cycles |
| tick | output | 1 | One-cycle terminal-count tick |
| pulse | output | 1 | High while the width counter runs |

## Verification
The risky coincidence is a tick that lands in the same cycle as the width counter's last active cycle, or in the middle of a pulse. In that cycle the expire path and the retrigger path compete. The bench provokes this with short periods under long widths, including a period shorter than the width, and with zero-width ticks in the middle of a pulse. The scoreboard model settles each such cycle from R5 to R7. A second collision, a load in the cycle the count hits zero, is provoked by repeated loads and judged by R9.

// File: rtl/pgen_pkg.sv
`timescale 1ns/1ps
package pgen_pkg;
    typedef enum logic {
        W_IDLE = 1'b0,
        W_RUN  = 1'b1
    } width_state_e;
endpackage

// File: rtl/pgen_period.sv
`timescale 1ns/1ps
// Down-counting period stage: emits a one-cycle tick at zero, reloads, runs on.
module pgen_period #(
    parameter int PERIOD_W = 28
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_en,
    input  logic [PERIOD_W-1:0] load_period,
    output logic                tick
);
    logic [PERIOD_W-1:0] period_q;
    logic [PERIOD_W-1:0] count_q;
    logic                at_zero;

    assign at_zero = (count_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= '0;
            count_q  <= '0;
            tick     <= 1'b0;
        end else if (load_en) begin
            period_q <= load_period;
            count_q  <= load_period;
            tick     <= 1'b0;
        end else if (at_zero) begin
            count_q  <= period_q;
            tick     <= 1'b1;
        end else begin
            count_q  <= count_q - 1'b1;
            tick     <= 1'b0;
        end
    end
endmodule

// File: rtl/pgen_width.sv
`timescale 1ns/1ps
// Width stage: two-state machine holding the output for a sampled width.
module pgen_width
    import pgen_pkg::*;
#(
    parameter int WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic [WIDTH_W-1:0] width,
    output logic               pulse
);
    width_state_e       state_q, state_d;
    logic [WIDTH_W-1:0] rem_q, rem_d;
    logic               width_nz;

    assign width_nz = (width != '0);

    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        unique case (state_q)
            W_IDLE: begin
                if (tick && width_nz) begin          // start
                    state_d = W_RUN;
                    rem_d   = width - 1'b1;
                end
            end
            W_RUN: begin
                if (tick) begin
                    if (width_nz) begin              // retrigger
                        rem_d = width - 1'b1;
                    end else begin                   // cancel
                        state_d = W_IDLE;
                        rem_d   = '0;
                    end
                end else if (rem_q == '0) begin      // expire
                    state_d = W_IDLE;
                end else begin
                    rem_d = rem_q - 1'b1;
                end
            end
            default: state_d = W_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= W_IDLE;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end

    // Output decode
    always_comb begin
        pulse = (state_q == W_RUN);
    end
endmodule

// File: rtl/pgen_pulse_train.sv
`timescale 1ns/1ps
module pgen_pulse_train #(
    parameter int PERIOD_W = 28,
    parameter int WIDTH_W  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_en,
    input  logic [PERIOD_W-1:0] load_period,
    input  logic [WIDTH_W-1:0]  pulse_width,
    output logic                tick,
    output logic                pulse
);
    pgen_period #(.PERIOD_W(PERIOD_W)) u_period (
        .clk         (clk),
        .rst         (rst),
        .load_en     (load_en),
        .load_period (load_period),
        .tick        (tick)
    );

    pgen_width #(.WIDTH_W(WIDTH_W)) u_width (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .width (pulse_width),
        .pulse (pulse)
    );
endmodule

// File: rtl/pgen_pulse_train_chk.sv
`timescale 1ns/1ps
module pgen_pulse_train_chk #(
    parameter int WIDTH_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               load_en,
    input logic [WIDTH_W-1:0] pulse_width,
    input logic               tick,
    input logic               pulse
);
    logic rst_d = 1'b0;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d) begin
            assert_reset_clear_R1: assert (!tick && !pulse)
                else $error("outputs not cleared by reset");
        end
    end

    assert_load_no_tick_R9: assert property (@(posedge clk) disable iff (rst)
        load_en |=> !tick);

    assert_start_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && pulse_width != '0) |=> pulse);

    assert_rise_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse) |-> $past(tick));

    assert_zero_width_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && pulse_width == '0) |=> !pulse);

    assert_fall_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(pulse) |-> (!$past(tick) || $past(pulse_width) == '0));
endmodule

bind pgen_pulse_train pgen_pulse_train_chk #(.WIDTH_W(WIDTH_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .load_en     (load_en),
    .pulse_width (pulse_width),
    .tick        (tick),
    .pulse       (pulse)
);

// File: tb/pgen_pulse_train_test.sv
`timescale 1ns/1ps
module pgen_pulse_train_test;
    localparam int PW = 28;
    localparam int WW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_en = 1'b0;
    logic [PW-1:0] load_period = '0;
    logic [WW-1:0] pulse_width = '0;
    logic          tick, pulse;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic [1:0] exp_q[$];
    string      tag_q[$];

    // reference state, derived from the requirements
    logic [PW-1:0] m_per = '0, m_cnt = '0;
    logic          m_tick = 1'b0, m_pulse = 1'b0;
    logic [WW-1:0] m_rem = '0;

    always #4 clk = ~clk;

    pgen_pulse_train #(.PERIOD_W(PW), .WIDTH_W(WW)) uut (
        .clk(clk), .rst(rst), .load_en(load_en), .load_period(load_period),
        .pulse_width(pulse_width), .tick(tick), .pulse(pulse)
    );

    // driver: apply inputs and push the value expected after the coming edge
    task automatic step(input logic r, input logic ld, input logic [PW-1:0] p,
                        input logic [WW-1:0] w, input string tag);
        @(negedge clk);
        rst = r; load_en = ld; load_period = p; pulse_width = w;
        if (r) begin
            m_per = '0; m_cnt = '0; m_tick = 0; m_pulse = 0; m_rem = '0;
        end else begin
            if (m_tick) begin
                if (w != 0) begin m_pulse = 1; m_rem = w - 1'b1; end
                else begin m_pulse = 0; m_rem = '0; end
            end else if (m_pulse && m_rem != 0) begin
                m_rem = m_rem - 1'b1;
            end else begin
                m_pulse = 0;
            end
            if (ld) begin m_per = p; m_cnt = p; m_tick = 0; end
            else if (m_cnt == 0) begin m_cnt = m_per; m_tick = 1; end
            else begin m_cnt = m_cnt - 1'b1; m_tick = 0; end
        end
        exp_q.push_back({m_tick, m_pulse});
        tag_q.push_back(tag);
    endtask

    task automatic run(input int n, input logic [WW-1:0] w, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 28'hABCDE, w, tag);
    endtask

    // monitor: pop and compare after each edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            vectors++;
            if ({tick, pulse} !== e) begin
                miscompares++;
                $display("FAIL %s: tick/pulse actual %b%b expected %b%b at %0t",
                         t, tick, pulse, e[1], e[0], $time);
            end
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 28'd0, 8'd0, "R1 reset");
        run(4, 8'd0, "R1 free tick after reset");
        step(1'b0, 1'b1, 28'd5, 8'd3, "R2 load 5");
        run(30, 8'd3, "R3/R5 period 5 width 3");
        run(20, 8'd1, "R5 width 1");
        // R8: width toggles outside tick cycles
        for (int i = 0; i < 40; i++) step(1'b0, 1'b0, 28'd0, (i % 2) ? 8'd2 : 8'd4, "R8 width changes");
        run(20, 8'd0, "R6 width 0");
        // R7: period 3 under width 6 -> retrigger
        step(1'b0, 1'b1, 28'd3, 8'd6, "R2 load 3");
        run(30, 8'd6, "R7 retrigger");
        // R6: zero-width tick ends running pulse
        step(1'b0, 1'b1, 28'd7, 8'd6, "R2 load 7");
        for (int i = 0; i < 40; i++) step(1'b0, 1'b0, 28'd0, (i % 16 < 8) ? 8'd6 : 8'd0, "R6 cancel");
        // R9: load every few cycles at short period, including terminal count
        for (int i = 0; i < 24; i++) step(1'b0, (i % 3) == 0, 28'd2, 8'd2, "R9 load priority");
        step(1'b0, 1'b1, 28'd1, 8'd1, "R2 load 1");
        for (int i = 0; i < 12; i++) step(1'b0, 1'b1, 28'd0, 8'd1, "R9 held load");
        // R4: period input moves without load
        step(1'b0, 1'b1, 28'd4, 8'd2, "R2 load 4");
        for (int i = 0; i < 30; i++) step(1'b0, 1'b0, 28'(i), 8'd2, "R4 period ignored");
        // long width against a longer period
        step(1'b0, 1'b1, 28'd300, 8'd255, "R2 load 300");
        run(650, 8'd255, "R5 width 255");
        step(1'b1, 1'b0, 28'd0, 8'd9, "R1 mid-run reset");
        run(5, 8'd2, "R1 after reset");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule